// File: doc/BRIEF.md
# Three-Weight Accumulator Pattern Generator

This block is a test-per-clock stimulus source for a circuit under test. It is built around a plain n-bit accumulator. The running sum register drives the pattern. A second register holds the addend. Each stage of the accumulator is given one of three weights: held at 0, held at 1, or left free so that it changes pseudorandomly (weight one half).

A stage is held by asynchronously setting or clearing its sum bit and, at the same time, forcing its addend bit to the complement value. A full adder whose two operand bits differ passes its carry-in straight to its carry-out. The free stages therefore keep accumulating as if the held stages were not there, and the adder itself is left untouched.

A session controller walks through a parameter table of weight assignments. Each entry lasts a fixed number of accepted patterns. A maximal-length shift register supplies the free addend bits at each session start.

The pattern leaves on a valid/ready stream. `pat_valid` rises on the first cycle after `start` and then stays high. A pattern is consumed on every cycle in which `pat_valid` and `pat_ready` are both high. While `pat_ready` is low, the pattern, the session index and the session position all hold. There is no limit on how long the consumer may stall.

Top module: `tw_pattern_gen`

## Requirements
- R1: After reset, and until `start` is seen, `pat_data` is 0, `pat_valid` is 0, `sess_idx` is 0 and `done` is 0.
- R2: On the cycle after `start` is sampled high in the idle state, `pat_valid` is 1 and `sess_idx` is 0. In that cycle, every bit of `pat_data` is 0 except the bits that session 0 holds at 1.
- R3: The 2-bit weight code for bit i of session s sits at `WEIGHTS[2*(s*WIDTH+i) +: 2]`. Code 10 holds that bit at 1 and code 01 holds it at 0, for every pattern of the session.
- R4: Within a session, concatenate the free bits in ascending bit order. The resulting value grows by a constant addend modulo 2^(free count) on every accepted pattern, so carries cross the held stages unchanged.
- R5: Codes 00 and 11 both leave a bit free. A code-11 bit is never held and takes part in the R4 sum.
- R6: `sess_idx` advances by one after `SESS_LEN` accepted patterns, and wraps from `NUM_SESS-1` to 0.
- R7: `done` rises in the same cycle that `sess_idx` first wraps to 0, and it stays 1 until reset.
- R8: While `pat_valid` is 1 and `pat_ready` is 0, `pat_data`, `sess_idx` and `done` hold, and stalled cycles do not count toward the session length.
- R9: `start` has no effect once the stream is running. The session position continues and `pat_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins generation when the block is idle |
| pat_data | output | WIDTH | Current pattern (the accumulator value) |
| pat_valid | output | 1 | Pattern is valid; high from the first cycle after start |
| pat_ready | input | 1 | Consumer accepts the pattern; low stalls the generator |
| sess_idx | output | $clog2(NUM_SESS) | Index of the active weight assignment |
| done | output | 1 | One full pass over all sessions has completed |

## Verification
The hardest behaviour to observe is the carry crossing a held stage, because the addend register cannot be seen from the ports. The stimulus lets each session run unstalled. The bench packs the free bits and learns the addend from the first step of each session. It then predicts every later pattern of that session from that addend alone. The third default session places a held bit between free bits and also uses code 11. A stall of several cycles, with a redundant `start` issued as it ends, is checked by counting how many accepted patterns pass before the next session change.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    WGT_RAND = 2'b00,
    WGT_ZERO = 2'b01,
    WGT_ONE  = 2'b10,
    WGT_BAD  = 2'b11
  } wgt_e;

  function automatic logic wgt_is_one(input logic [1:0] code);
    return code == WGT_ONE;
  endfunction

  function automatic logic wgt_is_zero(input logic [1:0] code);
    return code == WGT_ZERO;
  endfunction
endpackage

// File: rtl/tw_lfsr.sv
module tw_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/tw_sess_ctrl.sv
module tw_sess_ctrl
  import tw_pkg::*;
#(
  parameter int WIDTH    = 5,
  parameter int NUM_SESS = 3,
  parameter int SESS_LEN = 16,
  parameter logic [2*WIDTH*NUM_SESS-1:0] WEIGHTS = '0,
  localparam int SESS_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1,
  localparam int CNT_W  = (SESS_LEN > 1) ? $clog2(SESS_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pat_ready,
  output logic              run,
  output logic              adv,
  output logic              load,
  output logic              step,
  output logic [SESS_W-1:0] sess_idx,
  output logic              done,
  output logic [WIDTH-1:0]  frc1,
  output logic [WIDTH-1:0]  frc0
);
  localparam logic [SESS_W-1:0] LAST_SESS = SESS_W'(NUM_SESS - 1);
  localparam logic [CNT_W-1:0]  LAST_CNT  = CNT_W'(SESS_LEN - 1);

  logic [CNT_W-1:0]  cnt;
  logic              go, last;
  logic [SESS_W-1:0] nxt_sess;
  logic [WIDTH-1:0]  nx1, nx0;

  assign go   = !run && start;
  assign adv  = run && pat_ready;
  assign last = adv && (cnt == LAST_CNT);
  assign load = go || last;
  assign step = go || adv;

  always_comb begin
    if (go || sess_idx == LAST_SESS) nxt_sess = '0;
    else                             nxt_sess = sess_idx + 1'b1;
  end

  // decode the weight codes of the session about to begin
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      nx1[i] = wgt_is_one (WEIGHTS[2*(int'(nxt_sess)*WIDTH + i) +: 2]);
      nx0[i] = wgt_is_zero(WEIGHTS[2*(int'(nxt_sess)*WIDTH + i) +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cnt      <= '0;
      sess_idx <= '0;
      done     <= 1'b0;
      frc1     <= '0;
      frc0     <= '0;
    end else begin
      if (go) run <= 1'b1;
      if (go)       cnt <= '0;
      else if (adv) cnt <= last ? '0 : cnt + 1'b1;
      if (load) begin
        sess_idx <= nxt_sess;
        frc1     <= nx1;
        frc0     <= nx0;
      end
      if (last && sess_idx == LAST_SESS) done <= 1'b1;
    end
  end
endmodule

// File: rtl/tw_acc_cell.sv
module tw_acc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic frc1,
  input  logic frc0,
  input  logic en,
  input  logic load_b,
  input  logic b_seed,
  input  logic cin,
  output logic a_q,
  output logic cout
);
  logic b_q, sum_w;

  // unmodified full adder
  assign sum_w = a_q ^ b_q ^ cin;
  assign cout  = (a_q & b_q) | (cin & (a_q ^ b_q));

  // sum bit: forced high by frc1, low by frc0
  always_ff @(posedge clk or negedge rst_n or posedge frc1 or posedge frc0) begin
    if (!rst_n)    a_q <= 1'b0;
    else if (frc1) a_q <= 1'b1;
    else if (frc0) a_q <= 1'b0;
    else if (en)   a_q <= sum_w;
  end

  // addend bit: same lines, crossed, so it holds the complement
  always_ff @(posedge clk or negedge rst_n or posedge frc1 or posedge frc0) begin
    if (!rst_n)      b_q <= 1'b0;
    else if (frc1)   b_q <= 1'b0;
    else if (frc0)   b_q <= 1'b1;
    else if (load_b) b_q <= b_seed;
  end
endmodule

// File: rtl/tw_pattern_gen.sv
module tw_pattern_gen
  import tw_pkg::*;
#(
  parameter int WIDTH    = 5,
  parameter int NUM_SESS = 3,
  parameter int SESS_LEN = 16,
  parameter int LFSR_W   = 16,
  parameter logic [2*WIDTH*NUM_SESS-1:0] WEIGHTS =
    30'b1011000111_0000011001_0000100010,
  localparam int SESS_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [WIDTH-1:0]  pat_data,
  output logic              pat_valid,
  input  logic              pat_ready,
  output logic [SESS_W-1:0] sess_idx,
  output logic              done
);
  logic              run, adv, load, step;
  logic [WIDTH-1:0]  frc1, frc0, seed;
  logic [LFSR_W-1:0] lfsr;
  logic [WIDTH:0]    cy;

  tw_sess_ctrl #(
    .WIDTH(WIDTH), .NUM_SESS(NUM_SESS), .SESS_LEN(SESS_LEN), .WEIGHTS(WEIGHTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_ready(pat_ready),
    .run(run), .adv(adv), .load(load), .step(step),
    .sess_idx(sess_idx), .done(done), .frc1(frc1), .frc0(frc0)
  );

  tw_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(step), .state(lfsr)
  );

  // fold the whole shift register onto the addend width
  always_comb begin
    seed = '0;
    for (int j = 0; j < LFSR_W; j++) seed[j % WIDTH] ^= lfsr[j];
  end

  assign cy[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    tw_acc_cell u_cell (
      .clk(clk), .rst_n(rst_n), .frc1(frc1[i]), .frc0(frc0[i]),
      .en(adv), .load_b(load), .b_seed(seed[i]), .cin(cy[i]),
      .a_q(pat_data[i]), .cout(cy[i+1])
    );
  end

  assign pat_valid = run;
endmodule

// File: rtl/tw_pattern_gen_chk.sv
module tw_pattern_gen_chk #(
  parameter int WIDTH    = 5,
  parameter int NUM_SESS = 3,
  parameter logic [2*WIDTH*NUM_SESS-1:0] WEIGHTS = '0,
  localparam int SESS_W = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WIDTH-1:0]  pat_data,
  input logic              pat_valid,
  input logic              pat_ready,
  input logic [SESS_W-1:0] sess_idx,
  input logic              done
);
  function automatic logic [WIDTH-1:0] hold_mask(input logic [SESS_W-1:0] s,
                                                 input logic [1:0] code);
    logic [WIDTH-1:0] m;
    for (int i = 0; i < WIDTH; i++)
      m[i] = (WEIGHTS[2*(int'(s)*WIDTH + i) +: 2] == code);
    return m;
  endfunction

  logic [WIDTH-1:0] m1, m0;
  assign m1 = hold_mask(sess_idx, 2'b10);
  assign m0 = hold_mask(sess_idx, 2'b01);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_valid |-> (pat_data == '0 && !done));

  a_r3_held_levels: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> ((pat_data & m1) == m1 && (pat_data & m0) == '0));

  a_r3_held_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && $past(pat_valid) && sess_idx == $past(sess_idx))
      |-> (((pat_data ^ $past(pat_data)) & (m1 | m0)) == '0));

  a_r6_sess_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sess_idx) < NUM_SESS);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready) |=> ($stable(pat_data) && $stable(sess_idx) && $stable(done)));

  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |=> pat_valid);
endmodule

bind tw_pattern_gen tw_pattern_gen_chk #(
  .WIDTH(WIDTH), .NUM_SESS(NUM_SESS), .WEIGHTS(WEIGHTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pat_data(pat_data), .pat_valid(pat_valid),
  .pat_ready(pat_ready), .sess_idx(sess_idx), .done(done)
);

// File: tb/tb_tw_pattern_gen.sv
`timescale 1ns/1ps
module tb_tw_pattern_gen;
  localparam int W = 5;
  localparam int NS = 3;
  localparam int L = 16;

  // per session: {held-at-1 mask, held-at-0 mask}
  localparam logic [9:0] TAB [NS] = '{10'b00101_00000, 10'b00010_00101, 10'b10000_00010};

  logic clk = 1'b0;
  logic rst_n, start, pat_ready, pat_valid, done;
  logic [W-1:0] pat_data;
  logic [1:0] sess_idx;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tw_pattern_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_data(pat_data),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .sess_idx(sess_idx), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pack_free(input logic [W-1:0] v, input logic [W-1:0] fm);
    int r = 0;
    int n = 0;
    for (int i = 0; i < W; i++)
      if (fm[i]) begin
        r |= int'(v[i]) << n;
        n++;
      end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] m1, m0, fm, saved;
    logic [1:0] ssaved;
    int md, prev, cur, add, n;
    rst_n = 1'b0; start = 1'b0; pat_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset / idle state
    check(pat_data == '0, "R1 pat_data", pat_data, 0);
    check(!pat_valid, "R1 pat_valid", pat_valid, 0);
    check(sess_idx == 0, "R1 sess_idx", sess_idx, 0);
    check(!done, "R1 done", done, 0);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 first pattern
    check(pat_valid, "R2 pat_valid", pat_valid, 1);
    check(sess_idx == 0, "R2 sess_idx", sess_idx, 0);
    check(pat_data == TAB[0][9:5], "R2 pat_data", pat_data, TAB[0][9:5]);

    // table walk: one full pass over every session
    for (int s = 0; s < NS; s++) begin
      m1 = TAB[s][9:5];
      m0 = TAB[s][4:0];
      fm = ~(m1 | m0);
      md = 1 << $countones(fm);
      prev = 0; add = 0;
      for (int k = 0; k < L; k++) begin
        check(sess_idx == s, "R6 sess_idx", sess_idx, s);
        check((pat_data & m1) == m1 && (pat_data & m0) == '0,
              "R3 held bits", pat_data, m1);
        check(!done, "R7 done early", done, 0);
        cur = pack_free(pat_data, fm);
        if (k == 1) add = (cur - prev + md) % md;
        if (k >= 2)
          check(cur == (prev + add) % md, (s == 2) ? "R5 code11 free sum" : "R4 free sum",
                cur, (prev + add) % md);
        prev = cur;
        @(negedge clk);
      end
    end
    // wrap
    check(sess_idx == 0, "R6 wrap", sess_idx, 0);
    check(done, "R7 done at wrap", done, 1);
    check((pat_data & TAB[0][9:5]) == TAB[0][9:5] && (pat_data & TAB[0][4:0]) == '0,
          "R3 held after wrap", pat_data, TAB[0][9:5]);

    // stall at the first pattern of a session
    pat_ready = 1'b0;
    saved = pat_data;
    ssaved = sess_idx;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pat_data == saved, "R8 data held", pat_data, saved);
      check(sess_idx == ssaved, "R8 sess held", sess_idx, ssaved);
      check(pat_valid, "R8 valid", pat_valid, 1);
    end
    // release with a redundant start
    pat_ready = 1'b1;
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end while (sess_idx == 0 && n < 100);
    check(n == L, "R8 R9 session length after stall/start", n, L);
    check(sess_idx == 1, "R9 session continues", sess_idx, 1);
    check(pat_valid, "R9 valid stays", pat_valid, 1);
    check(done, "R7 done sticky", done, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule